// File: doc/BRIEF.md
# Accumulator Microcontroller Core

This block is a compact 8-bit processor core built around one working register (W). It reads 12-bit instruction words from an external program memory through an address output and a combinational data input. Inside it has a small register file with a shared lower half, a banked upper half, a status register and an output-port register whose value drives a pin bus. Program flow is steered by unconditional jumps, subroutine calls through a two-entry hidden return stack, and skip instructions that cancel the word already fetched behind them. A lookup table in program memory is read by calling into a run of return-with-literal words.

Every instruction cycle is a fixed walk through four phase states: `PH_DECODE` latches the decoded control word, `PH_READ` latches the operand (register or literal), `PH_EXEC` latches the ALU result and the skip decision, and `PH_WRITE` commits results, updates the stack and the program counter, and loads the next instruction word. The transitions are `PH_DECODE -> PH_READ -> PH_EXEC -> PH_WRITE -> PH_DECODE` with no other branch. The word at the program counter is fetched while the previous word executes. A jump, call, return or taken skip replaces the fetched word with a no-operation, which costs one extra instruction cycle.

Top module: `mcu_core`

## Requirements
- R1: Reset sets the program counter to the last program address (all ones; program memory word 0x1FF must hold a jump to the program start), clears W, the status register, the port register, every file register and both stack entries, and enters `PH_DECODE` with a no-operation (word 0x000) in the instruction register.
- R2: A byte-register word is `00 oooo d fffff`: bits 9:6 select the operation, bit 5 is the destination flag and bits 4:0 the register address. With the flag at 0 the result goes to W; at 1 it goes back to the register. Sub-op 0x0 with the flag at 1 stores W into the register; with the flag at 0 it is a no-operation.
- R3: Byte sub-ops: 0x1 clear, 0x2 register minus W, 0x3 decrement, 0x4 OR, 0x5 AND, 0x6 XOR, 0x7 add, 0x8 move register, 0x9 complement, 0xA increment (all 8-bit, wrapping); 0xD to 0xF do nothing.
- R4: Literal words are `oooo kkkkkkkk`: 0xC loads k into W, 0xD ORs k into W, 0xE ANDs k into W, 0xF XORs k into W.
- R5: A bit word is `01 oo bbb fffff` with bit index in bits 7:5; op 00 clears and op 01 sets that bit of the register.
- R6: Bit op 10 skips the next word when the selected bit is 0; bit op 11 skips when it is 1.
- R7: Byte sub-op 0xB decrements and 0xC increments the register (destination per flag) and skip the next word when the result is zero; neither changes the zero flag.
- R8: The zero flag is bit 2 of the status register at address 0x03; byte sub-ops 0x1 to 0xA and literal ops 0xD to 0xF set it when the result is zero and clear it otherwise. When such an operation also writes the status register, the flag update wins for bit 2.
- R9: A sequential instruction takes 4 clocks; a jump, call, return or taken skip takes 8 clocks, the second instruction cycle executing a no-operation in place of the fetched word.
- R10: Word `101 aaaaaaaaa` jumps to the 9-bit address a; word `1001 kkkkkkkk` pushes the address of the following word and jumps to k (zero-extended).
- R11: The return stack holds two entries; a third nested call discards the oldest entry, and a return from an emptied stack returns to the most recently returned address again.
- R12: Word `1000 kkkkkkkk` loads k into W and returns to the popped address, without changing the zero flag.
- R13: Addresses 0x00 to 0x0F are shared, 0x06 is the port register driving `port_out`, and 0x10 to 0x1F select one of two banks by status bit 5; the port changes only when address 0x06 is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; one instruction cycle is four rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_addr | output | PC_W | Program counter, address of the word being fetched |
| rom_data | input | 12 | Instruction word at `rom_addr`, combinational |
| port_out | output | 8 | Contents of the output-port register |

## Verification
The assertions assume that `rom_data` is a settled function of `rom_addr` by the end of each `PH_WRITE` phase and that reset is released clear of a clock edge; the bench models program memory as a combinational array and changes reset only on falling edges. They also rely on the core never asking the stack to push and pop in one cycle, which holds because one instruction is either a call or a return. Programs use only defined encodings, never make a zero-flag operation write the status register, and expect each port change at a clock edge counted from reset release.

// File: rtl/mcu_pkg.sv
package mcu_pkg;

    localparam int INSTR_W   = 12;
    localparam int DATA_W    = 8;
    localparam int FADDR_W   = 5;
    localparam int JUMP_W    = 9;

    localparam logic [FADDR_W-1:0] ADDR_STATUS = 5'h03;
    localparam logic [FADDR_W-1:0] ADDR_PORT   = 5'h06;
    localparam int ZERO_BIT  = 2;
    localparam int BANK_LSB  = 5;

    localparam logic [INSTR_W-1:0] WORD_NOP = '0;

    typedef enum logic [1:0] {
        PH_DECODE,
        PH_READ,
        PH_EXEC,
        PH_WRITE
    } phase_e;

    typedef enum logic [3:0] {
        ALU_PASS_W,
        ALU_ZERO,
        ALU_SUB,
        ALU_DEC,
        ALU_OR,
        ALU_AND,
        ALU_XOR,
        ALU_ADD,
        ALU_PASS_B,
        ALU_NOT,
        ALU_INC,
        ALU_BCLR,
        ALU_BSET,
        ALU_NONE
    } alu_e;

    typedef enum logic [1:0] {
        SK_NONE,
        SK_ZERO,
        SK_BIT_CLR,
        SK_BIT_SET
    } skip_e;

    typedef enum logic [1:0] {
        FL_SEQ,
        FL_GOTO,
        FL_CALL,
        FL_RET
    } flow_e;

    typedef struct packed {
        alu_e                alu;
        logic                use_lit;
        logic                wr_w;
        logic                wr_f;
        logic                upd_z;
        skip_e               skip;
        flow_e               flow;
        logic [2:0]          bitsel;
        logic [FADDR_W-1:0]  faddr;
        logic [DATA_W-1:0]   lit;
        logic [JUMP_W-1:0]   target;
    } ctrl_t;

endpackage

// File: rtl/mcu_decode.sv
module mcu_decode
    import mcu_pkg::*;
(
    input  logic [INSTR_W-1:0] ir,
    output ctrl_t              ctrl
);

    logic dflag;
    assign dflag = ir[5];

    always_comb begin
        ctrl         = '0;
        ctrl.alu     = ALU_NONE;
        ctrl.skip    = SK_NONE;
        ctrl.flow    = FL_SEQ;
        ctrl.bitsel  = ir[7:5];
        ctrl.faddr   = ir[4:0];
        ctrl.lit     = ir[7:0];
        ctrl.target  = ir[8:0];
        unique case (ir[11:10])
            2'b00: begin
                ctrl.wr_w  = !dflag;
                ctrl.wr_f  = dflag;
                ctrl.upd_z = 1'b1;
                unique case (ir[9:6])
                    4'h0: begin
                        ctrl.alu   = ALU_PASS_W;
                        ctrl.wr_w  = 1'b0;
                        ctrl.upd_z = 1'b0;
                    end
                    4'h1: ctrl.alu = ALU_ZERO;
                    4'h2: ctrl.alu = ALU_SUB;
                    4'h3: ctrl.alu = ALU_DEC;
                    4'h4: ctrl.alu = ALU_OR;
                    4'h5: ctrl.alu = ALU_AND;
                    4'h6: ctrl.alu = ALU_XOR;
                    4'h7: ctrl.alu = ALU_ADD;
                    4'h8: ctrl.alu = ALU_PASS_B;
                    4'h9: ctrl.alu = ALU_NOT;
                    4'hA: ctrl.alu = ALU_INC;
                    4'hB: begin
                        ctrl.alu   = ALU_DEC;
                        ctrl.skip  = SK_ZERO;
                        ctrl.upd_z = 1'b0;
                    end
                    4'hC: begin
                        ctrl.alu   = ALU_INC;
                        ctrl.skip  = SK_ZERO;
                        ctrl.upd_z = 1'b0;
                    end
                    default: begin
                        ctrl.wr_w  = 1'b0;
                        ctrl.wr_f  = 1'b0;
                        ctrl.upd_z = 1'b0;
                    end
                endcase
            end
            2'b01: begin
                unique case (ir[9:8])
                    2'b00: begin ctrl.alu = ALU_BCLR; ctrl.wr_f = 1'b1; end
                    2'b01: begin ctrl.alu = ALU_BSET; ctrl.wr_f = 1'b1; end
                    2'b10: ctrl.skip = SK_BIT_CLR;
                    2'b11: ctrl.skip = SK_BIT_SET;
                endcase
            end
            default: begin
                ctrl.use_lit = 1'b1;
                unique case (ir[11:8])
                    4'h8: begin
                        ctrl.alu  = ALU_PASS_B;
                        ctrl.wr_w = 1'b1;
                        ctrl.flow = FL_RET;
                    end
                    4'h9: begin
                        ctrl.flow   = FL_CALL;
                        ctrl.target = {1'b0, ir[7:0]};
                    end
                    4'hA, 4'hB: ctrl.flow = FL_GOTO;
                    4'hC: begin ctrl.alu = ALU_PASS_B; ctrl.wr_w = 1'b1; end
                    4'hD: begin ctrl.alu = ALU_OR;  ctrl.wr_w = 1'b1; ctrl.upd_z = 1'b1; end
                    4'hE: begin ctrl.alu = ALU_AND; ctrl.wr_w = 1'b1; ctrl.upd_z = 1'b1; end
                    default: begin ctrl.alu = ALU_XOR; ctrl.wr_w = 1'b1; ctrl.upd_z = 1'b1; end
                endcase
            end
        endcase
    end

endmodule

// File: rtl/mcu_regfile.sv
module mcu_regfile
    import mcu_pkg::*;
#(
    parameter int BANK_SEL_W = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FADDR_W-1:0] raddr,
    output logic [DATA_W-1:0]  rdata,
    input  logic               we,
    input  logic [FADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               z_we,
    input  logic               z_in,
    output logic [DATA_W-1:0]  port_out
);

    localparam int BANKS     = 1 << BANK_SEL_W;
    localparam int HALF      = 1 << (FADDR_W - 1);
    localparam int BIDX_W    = BANK_SEL_W + FADDR_W - 1;

    logic [DATA_W-1:0] shared_q [HALF];
    logic [DATA_W-1:0] banked_q [BANKS*HALF];
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] port_q;
    logic [BANK_SEL_W-1:0] bank;
    logic [BIDX_W-1:0] ridx, widx;

    assign bank     = status_q[BANK_LSB +: BANK_SEL_W];
    assign ridx     = {bank, raddr[FADDR_W-2:0]};
    assign widx     = {bank, waddr[FADDR_W-2:0]};
    assign port_out = port_q;

    always_comb begin
        if (raddr == ADDR_STATUS)        rdata = status_q;
        else if (raddr == ADDR_PORT)     rdata = port_q;
        else if (!raddr[FADDR_W-1])      rdata = shared_q[raddr[FADDR_W-2:0]];
        else                             rdata = banked_q[ridx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            port_q   <= '0;
            for (int i = 0; i < HALF; i++)       shared_q[i] <= '0;
            for (int i = 0; i < BANKS*HALF; i++) banked_q[i] <= '0;
        end else begin
            if (we) begin
                if (waddr == ADDR_STATUS)        status_q <= wdata;
                else if (waddr == ADDR_PORT)     port_q <= wdata;
                else if (!waddr[FADDR_W-1])      shared_q[waddr[FADDR_W-2:0]] <= wdata;
                else                             banked_q[widx] <= wdata;
            end
            if (z_we) status_q[ZERO_BIT] <= z_in;
        end
    end

    // R13: port register only moves on a write to its address
    p_port_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && waddr == ADDR_PORT) |=> $stable(port_out));

    // R8: zero-flag strobe lands in status bit 2
    p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        z_we |=> (status_q[ZERO_BIT] == $past(z_in)));

endmodule

// File: rtl/mcu_retstack.sv
module mcu_retstack #(
    parameter int AW    = 9,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_val,
    output logic [AW-1:0] top
);

    logic [AW-1:0] ent_q [DEPTH];

    assign top = ent_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else if (push) begin
            ent_q[0] <= push_val;
            for (int i = 1; i < DEPTH; i++) ent_q[i] <= ent_q[i-1];
        end else if (pop) begin
            for (int i = 0; i < DEPTH-1; i++) ent_q[i] <= ent_q[i+1];
        end
    end

    // R11: the core never requests both operations at once
    p_no_push_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

    // R11: a push shifts toward the bottom, dropping the oldest entry
    p_push_shift_r11: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (ent_q[DEPTH-1] == $past(ent_q[DEPTH-2])));

    // R11: a pop leaves the bottom entry in place so it can be returned again
    p_pop_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> $stable(ent_q[DEPTH-1]));

endmodule

// File: rtl/mcu_core.sv
module mcu_core
    import mcu_pkg::*;
#(
    parameter int PC_W        = 9,
    parameter int STACK_DEPTH = 2,
    parameter int BANK_SEL_W  = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [PC_W-1:0]     rom_addr,
    input  logic [INSTR_W-1:0]  rom_data,
    output logic [DATA_W-1:0]   port_out
);

    phase_e             phase_q, phase_d;
    logic [PC_W-1:0]    pc_q, pc_d;
    logic [INSTR_W-1:0] ir_q;
    logic [DATA_W-1:0]  w_q;
    ctrl_t              ctrl_d, ctrl_q;
    logic [DATA_W-1:0]  opnd_q, res_q, alu_y, rf_rdata;
    logic               skip_q, skip_d;
    logic               latch_ctrl, latch_opnd, latch_res, commit;
    logic               redirect, stk_push, stk_pop;
    logic [PC_W-1:0]    stk_top;

    assign rom_addr = pc_q;

    mcu_decode u_decode (
        .ir   (ir_q),
        .ctrl (ctrl_d)
    );

    mcu_regfile #(.BANK_SEL_W(BANK_SEL_W)) u_regfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .raddr    (ctrl_q.faddr),
        .rdata    (rf_rdata),
        .we       (commit && ctrl_q.wr_f),
        .waddr    (ctrl_q.faddr),
        .wdata    (res_q),
        .z_we     (commit && ctrl_q.upd_z),
        .z_in     (res_q == '0),
        .port_out (port_out)
    );

    mcu_retstack #(.AW(PC_W), .DEPTH(STACK_DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (stk_push),
        .pop      (stk_pop),
        .push_val (pc_q),
        .top      (stk_top)
    );

    // Phase state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_DECODE;
        else        phase_q <= phase_d;
    end

    always_comb begin
        unique case (phase_q)
            PH_DECODE: phase_d = PH_READ;
            PH_READ:   phase_d = PH_EXEC;
            PH_EXEC:   phase_d = PH_WRITE;
            PH_WRITE:  phase_d = PH_DECODE;
        endcase
    end

    // Phase strobes
    always_comb begin
        latch_ctrl = 1'b0;
        latch_opnd = 1'b0;
        latch_res  = 1'b0;
        commit     = 1'b0;
        unique case (phase_q)
            PH_DECODE: latch_ctrl = 1'b1;
            PH_READ:   latch_opnd = 1'b1;
            PH_EXEC:   latch_res  = 1'b1;
            PH_WRITE:  commit     = 1'b1;
        endcase
    end

    // ALU
    always_comb begin
        logic [DATA_W-1:0] mask;
        mask = DATA_W'(1) << ctrl_q.bitsel;
        unique case (ctrl_q.alu)
            ALU_PASS_W: alu_y = w_q;
            ALU_ZERO:   alu_y = '0;
            ALU_SUB:    alu_y = opnd_q - w_q;
            ALU_DEC:    alu_y = opnd_q - 1'b1;
            ALU_OR:     alu_y = opnd_q | w_q;
            ALU_AND:    alu_y = opnd_q & w_q;
            ALU_XOR:    alu_y = opnd_q ^ w_q;
            ALU_ADD:    alu_y = opnd_q + w_q;
            ALU_PASS_B: alu_y = opnd_q;
            ALU_NOT:    alu_y = ~opnd_q;
            ALU_INC:    alu_y = opnd_q + 1'b1;
            ALU_BCLR:   alu_y = opnd_q & ~mask;
            ALU_BSET:   alu_y = opnd_q | mask;
            default:    alu_y = opnd_q;
        endcase
        unique case (ctrl_q.skip)
            SK_NONE:    skip_d = 1'b0;
            SK_ZERO:    skip_d = (alu_y == '0);
            SK_BIT_CLR: skip_d = !opnd_q[ctrl_q.bitsel];
            SK_BIT_SET: skip_d = opnd_q[ctrl_q.bitsel];
        endcase
    end

    assign redirect = (ctrl_q.flow != FL_SEQ);
    assign stk_push = commit && (ctrl_q.flow == FL_CALL);
    assign stk_pop  = commit && (ctrl_q.flow == FL_RET);

    always_comb begin
        unique case (ctrl_q.flow)
            FL_GOTO, FL_CALL: pc_d = PC_W'(ctrl_q.target);
            FL_RET:           pc_d = stk_top;
            FL_SEQ:           pc_d = pc_q + 1'b1;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q   <= '1;
            ir_q   <= WORD_NOP;
            w_q    <= '0;
            ctrl_q <= '0;
            opnd_q <= '0;
            res_q  <= '0;
            skip_q <= 1'b0;
        end else begin
            if (latch_ctrl) ctrl_q <= ctrl_d;
            if (latch_opnd) opnd_q <= ctrl_q.use_lit ? ctrl_q.lit : rf_rdata;
            if (latch_res) begin
                res_q  <= alu_y;
                skip_q <= skip_d;
            end
            if (commit) begin
                if (ctrl_q.wr_w) w_q <= res_q;
                pc_q <= pc_d;
                ir_q <= (redirect || skip_q) ? WORD_NOP : rom_data;
            end
        end
    end

    // R9: phases advance in a fixed ring
    p_phase_ring_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_WRITE) |=> (phase_q == PH_DECODE));

    // R9: the fetch address only moves at the end of an instruction cycle
    p_pc_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_WRITE) |=> $stable(pc_q));

    // R2: W only changes in the commit phase
    p_w_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_WRITE) |=> $stable(w_q));

    // R12: a return resumes at the address the stack offered
    p_ret_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stk_pop |=> (pc_q == $past(stk_top)));

    // R10: a call pushes exactly once per instruction cycle
    p_call_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stk_push |=> !stk_push);

endmodule

// File: tb/test_mcu_core.sv
module test_mcu_core;

    localparam int PCW = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PCW-1:0]   rom_addr;
    logic [11:0]      rom_data;
    logic [7:0]       port_out;
    logic [11:0]      rom [1 << PCW];

    assign rom_data = rom[rom_addr];

    always #2 clk = ~clk;

    mcu_core #(.PC_W(PCW)) i_mcu_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .rom_addr (rom_addr),
        .rom_data (rom_data),
        .port_out (port_out)
    );

    // encodings taken from the requirements
    localparam logic [3:0] B_MOVWF = 4'h0, B_CLR = 4'h1, B_SUB = 4'h2, B_ADD = 4'h7,
                           B_AND = 4'h5, B_MOVF = 4'h8, B_COM = 4'h9, B_INC = 4'hA,
                           B_DECSZ = 4'hB, B_INCSZ = 4'hC;
    localparam logic [1:0] T_CLR = 2'b00, T_SET = 2'b01, T_SKC = 2'b10, T_SKS = 2'b11;
    localparam logic [3:0] L_RET = 4'h8, L_CALL = 4'h9, L_MOV = 4'hC, L_IOR = 4'hD, L_XOR = 4'hF;

    function automatic logic [11:0] wb(input logic [3:0] s, input logic d, input logic [4:0] f);
        return {2'b00, s, d, f};
    endfunction
    function automatic logic [11:0] wt(input logic [1:0] o, input logic [2:0] b, input logic [4:0] f);
        return {2'b01, o, b, f};
    endfunction
    function automatic logic [11:0] wl(input logic [3:0] o, input logic [7:0] k);
        return {o, k};
    endfunction
    function automatic logic [11:0] wg(input logic [8:0] a);
        return {3'b101, a};
    endfunction

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    logic [7:0] prev = '0;
    logic [7:0] q_val [$];
    int         q_edge [$];
    string      q_req [$];

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic expect_port(input logic [7:0] v, input int e, input string r);
        q_val.push_back(v);
        q_edge.push_back(e);
        q_req.push_back(r);
    endtask

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (!rst_n) begin
            prev = port_out;
        end else if (port_out !== prev) begin
            if (q_val.size() == 0) begin
                check(1'b0, "R13", "unexpected port change", int'(port_out), int'(prev));
            end else begin
                logic [7:0] ev;
                int ee;
                string er;
                ev = q_val.pop_front();
                ee = q_edge.pop_front();
                er = q_req.pop_front();
                check(port_out == ev, er, "port value", int'(port_out), int'(ev));
                n_tests--;
                check(cyc == ee, er, "port change edge", cyc, ee);
                n_tests--;
                n_tests++;
            end
            prev = port_out;
        end
    end

    task automatic start_test();
        @(negedge clk);
        rst_n = 1'b0;
        for (int a = 0; a < (1 << PCW); a++) rom[a] = 12'h000;
        rom[(1 << PCW) - 1] = wg(9'h000);
    endtask

    task automatic release_and_wait();
        int t;
        repeat (2) @(negedge clk);
        // R1: reset state at the ports
        check(port_out == 8'h00, "R1", "port under reset", int'(port_out), 0);
        check(rom_addr == '1, "R1", "fetch address under reset", int'(rom_addr), (1 << PCW) - 1);
        rst_n = 1'b1;
        t = 0;
        while (q_val.size() != 0 && t < 400) begin
            @(negedge clk);
            t++;
        end
        check(q_val.size() == 0, "R9", "pending port events", q_val.size(), 0);
        q_val.delete();
        q_edge.delete();
        q_req.delete();
        repeat (40) @(negedge clk);
    endtask

    initial begin
        for (int a = 0; a < (1 << PCW); a++) rom[a] = 12'h000;

        // Program A: byte and literal arithmetic, destination flag
        start_test();
        rom[0]  = wl(L_MOV, 8'h5A);
        rom[1]  = wb(B_MOVWF, 1'b1, 5'h06);
        rom[2]  = wb(B_MOVWF, 1'b1, 5'h08);
        rom[3]  = wl(L_MOV, 8'h0F);
        rom[4]  = wb(B_AND, 1'b0, 5'h08);
        rom[5]  = wb(B_MOVWF, 1'b1, 5'h06);
        rom[6]  = wl(L_XOR, 8'hFF);
        rom[7]  = wb(B_MOVWF, 1'b1, 5'h06);
        rom[8]  = wb(B_INC, 1'b1, 5'h08);
        rom[9]  = wb(B_MOVF, 1'b0, 5'h08);
        rom[10] = wb(B_ADD, 1'b0, 5'h08);
        rom[11] = wb(B_MOVWF, 1'b1, 5'h06);
        rom[12] = wb(B_SUB, 1'b0, 5'h08);
        rom[13] = wb(B_MOVWF, 1'b1, 5'h06);
        rom[14] = wb(B_COM, 1'b1, 5'h06);
        rom[15] = wg(9'd15);
        expect_port(8'h5A, 20, "R4");
        expect_port(8'h0A, 36, "R2");
        expect_port(8'hF5, 44, "R4");
        expect_port(8'hB6, 60, "R3");
        expect_port(8'hA5, 68, "R3");
        expect_port(8'h5A, 72, "R2");
        release_and_wait();

        // Program B: skips, zero flag, jump timing
        start_test();
        rom[0]  = wl(L_MOV, 8'h02);
        rom[1]  = wb(B_MOVWF, 1'b1, 5'h09);
        rom[2]  = wl(L_MOV, 8'h01);
        rom[3]  = wb(B_MOVWF, 1'b1, 5'h06);
        rom[4]  = wb(B_DECSZ, 1'b1, 5'h09);
        rom[5]  = wg(9'd7);
        rom[6]  = wb(B_CLR, 1'b1, 5'h06);
        rom[7]  = wb(B_INC, 1'b1, 5'h06);
        rom[8]  = wb(B_DECSZ, 1'b1, 5'h09);
        rom[9]  = wb(B_CLR, 1'b1, 5'h06);
        rom[10] = wb(B_INC, 1'b1, 5'h06);
        rom[11] = wb(B_MOVF, 1'b0, 5'h09);
        rom[12] = wt(T_SKS, 3'd2, 5'h03);
        rom[13] = wb(B_CLR, 1'b1, 5'h06);
        rom[14] = wl(L_MOV, 8'h80);
        rom[15] = wb(B_MOVWF, 1'b1, 5'h06);
        rom[16] = wt(T_SKC, 3'd7, 5'h06);
        rom[17] = wt(T_CLR, 3'd7, 5'h06);
        rom[18] = wt(T_SET, 3'd3, 5'h06);
        rom[19] = wt(T_SKC, 3'd0, 5'h06);
        rom[20] = wb(B_CLR, 1'b1, 5'h06);
        rom[21] = wl(L_MOV, 8'hFF);
        rom[22] = wb(B_MOVWF, 1'b1, 5'h0A);
        rom[23] = wb(B_INCSZ, 1'b1, 5'h0A);
        rom[24] = wb(B_CLR, 1'b1, 5'h06);
        rom[25] = wt(T_SET, 3'd0, 5'h06);
        rom[26] = wg(9'd26);
        expect_port(8'h01, 28, "R9");
        expect_port(8'h02, 44, "R10");   // jump costs 8 clocks
        expect_port(8'h03, 56, "R7");    // decrement-skip taken
        expect_port(8'h80, 76, "R8");    // zero flag tested through status
        expect_port(8'h00, 84, "R6");    // bit-clear skip not taken
        expect_port(8'h08, 88, "R5");
        expect_port(8'h09, 116, "R7");   // increment-skip taken after bit skip
        release_and_wait();

        // Program C: calls, table return, stack overflow and underflow
        start_test();
        rom[0]     = wl(L_CALL, 8'h40);
        rom[1]     = wb(B_MOVWF, 1'b1, 5'h06);
        rom[2]     = wl(L_CALL, 8'h50);
        rom[3]     = wb(B_CLR, 1'b1, 5'h06);
        rom[9'h40] = wl(L_RET, 8'h33);
        rom[9'h50] = wl(L_CALL, 8'h60);
        rom[9'h51] = wb(B_MOVWF, 1'b1, 5'h06);
        rom[9'h52] = wl(L_RET, 8'h66);
        rom[9'h60] = wl(L_CALL, 8'h70);
        rom[9'h61] = wb(B_MOVWF, 1'b1, 5'h06);
        rom[9'h62] = wl(L_RET, 8'h55);
        rom[9'h70] = wl(L_RET, 8'h44);
        expect_port(8'h33, 32, "R12");
        expect_port(8'h44, 68, "R10");
        expect_port(8'h55, 80, "R11");   // third call dropped the oldest entry
        expect_port(8'h66, 92, "R11");   // emptied stack returns the last address again
        release_and_wait();

        // Program D: banked and shared registers
        start_test();
        rom[0]  = wl(L_MOV, 8'h11);
        rom[1]  = wb(B_MOVWF, 1'b1, 5'h12);
        rom[2]  = wt(T_SET, 3'd5, 5'h03);
        rom[3]  = wl(L_MOV, 8'h22);
        rom[4]  = wb(B_MOVWF, 1'b1, 5'h12);
        rom[5]  = wb(B_MOVF, 1'b0, 5'h12);
        rom[6]  = wb(B_MOVWF, 1'b1, 5'h06);
        rom[7]  = wt(T_CLR, 3'd5, 5'h03);
        rom[8]  = wb(B_MOVF, 1'b0, 5'h12);
        rom[9]  = wb(B_MOVWF, 1'b1, 5'h06);
        rom[10] = wb(B_MOVWF, 1'b1, 5'h05);
        rom[11] = wt(T_SET, 3'd5, 5'h03);
        rom[12] = wb(B_COM, 1'b0, 5'h05);
        rom[13] = wb(B_MOVWF, 1'b1, 5'h06);
        rom[14] = wg(9'd14);
        expect_port(8'h22, 40, "R13");
        expect_port(8'h11, 52, "R13");
        expect_port(8'hEE, 68, "R13");
        release_and_wait();

        // Program E: reset cleared W and the stack
        start_test();
        rom[0] = wl(L_IOR, 8'h01);
        rom[1] = wb(B_MOVWF, 1'b1, 5'h06);
        rom[2] = wl(L_RET, 8'h07);
        expect_port(8'h01, 20, "R1");
        expect_port(8'h07, 36, "R1");
        release_and_wait();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R9 watchdog: actual 0x%0h expected 0x%0h", 100000, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule